// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit settles whether a relative branch is taken. It looks at four status flags (sign, carry, zero, overflow) through a 4-bit selection mask taken from the instruction, and it works in one of two condition families. In the "any-set" family the branch is taken when at least one selected flag is set. In the "all-clear" family it is taken when every selected flag is clear. The same unit also works out the address that follows.

A start strobe captures one request. On the next clock edge the unit registers the decision and the next program counter, and it raises a one-cycle done pulse. A taken branch moves to the current PC plus the sign-extended 8-bit displacement. A branch that is not taken moves to the current PC plus one. All address arithmetic wraps around the PC width. The outputs keep their values until the next start. Flag generation and instruction fetch are handled elsewhere.

Top module: `brcond_unit`

## Requirements
- R1: During and after reset, before any start, taken_o is 0, next_pc_o is 0 and done_o is 0.
- R2: done_o is high in exactly the cycle after each cycle in which start_i is high, and low otherwise.
- R3: With fam_i = 0 (any-set family), mask bit 0 selects sign, bit 1 selects carry and bit 2 selects zero. The branch is taken if at least one selected flag is 1.
- R4: With fam_i = 0, mask bit 3 and the overflow flag have no effect on the decision.
- R5: With fam_i = 0 and mask bits 2..0 all zero, the branch is never taken.
- R6: With fam_i = 1 (all-clear family), mask bits 0..3 select sign, carry, zero and overflow. The branch is taken only if every selected flag is 0.
- R7: With fam_i = 1 and mask 0, the branch is taken whatever the flags are.
- R8: When the branch is taken, next_pc_o equals pc_i plus disp_i read as a signed byte, modulo 2^16.
- R9: When the branch is not taken, next_pc_o equals pc_i plus 1, modulo 2^16.
- R10: While start_i is low, taken_o and next_pc_o keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate the present inputs this cycle |
| fam_i | input | 1 | Condition family: 0 any-set, 1 all-clear |
| mask_i | input | 4 | Flag selection mask |
| flag_sign_i | input | 1 | Sign flag |
| flag_carry_i | input | 1 | Carry flag |
| flag_zero_i | input | 1 | Zero flag |
| flag_ovf_i | input | 1 | Overflow flag |
| pc_i | input | 16 | Current program counter |
| disp_i | input | 8 | Signed displacement |
| taken_o | output | 1 | Registered branch decision |
| next_pc_o | output | 16 | Registered next program counter |
| done_o | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The assertions assume that every input is a known value on the edge where start_i is sampled. They also assume that nothing outside a start cycle needs to be evaluated. Their clocked checks therefore look only one cycle past a start or a non-start. The stimulus sets all request fields together with start_i on the falling edge and drops start_i on the next falling edge. Between requests it changes the fields with start_i low, which exercises the hold behaviour while keeping every sampled request well defined.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
   // flag vector bit positions (match mask bit positions)
   localparam int unsigned FLG_SIGN  = 0;
   localparam int unsigned FLG_CARRY = 1;
   localparam int unsigned FLG_ZERO  = 2;
   localparam int unsigned FLG_OVF   = 3;
   localparam int unsigned FLG_COUNT = 4;

   typedef enum logic {
      FAM_ANY_SET   = 1'b0,
      FAM_ALL_CLEAR = 1'b1
   } br_family_e;
endpackage

// File: rtl/brcond_eval.sv
module brcond_eval
   import brcond_pkg::*;
#(
   parameter int unsigned NFLAG     = FLG_COUNT,
   parameter int unsigned ANY_FLAGS = 3
) (
   input  logic             fam_i,
   input  logic [NFLAG-1:0] mask_i,
   input  logic [NFLAG-1:0] flags_i,
   output logic             taken_o
);
   localparam int unsigned ALL_FLAGS = NFLAG;

   if (ANY_FLAGS > NFLAG) begin : g_bad_any
      $error("ANY_FLAGS must not exceed NFLAG");
   end

   logic [NFLAG-1:0] hit_any;
   logic [NFLAG-1:0] ok_clear;

   for (genvar i = 0; i < NFLAG; i++) begin : g_term
      if (i < ANY_FLAGS) begin : g_any
         assign hit_any[i] = mask_i[i] & flags_i[i];
      end else begin : g_noany
         assign hit_any[i] = 1'b0;
      end
      if (i < ALL_FLAGS) begin : g_all
         assign ok_clear[i] = ~mask_i[i] | ~flags_i[i];
      end else begin : g_noall
         assign ok_clear[i] = 1'b1;
      end
   end

   always_comb begin
      if (br_family_e'(fam_i) == FAM_ALL_CLEAR) taken_o = &ok_clear;
      else                                      taken_o = |hit_any;
   end
endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
   parameter int unsigned PC_W   = 16,
   parameter int unsigned DISP_W = 8
) (
   input  logic [PC_W-1:0]   pc_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic              taken_i,
   output logic [PC_W-1:0]   next_pc_o
);
   localparam int unsigned EXT_W = PC_W - DISP_W;

   if (DISP_W == 0 || DISP_W > PC_W) begin : g_bad_w
      $error("DISP_W must be in 1..PC_W");
   end

   logic [PC_W-1:0] disp_ext;
   logic [PC_W-1:0] jump_pc;
   logic [PC_W-1:0] seq_pc;

   if (EXT_W == 0) begin : g_noext
      assign disp_ext = disp_i;
   end else begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
   end

   assign jump_pc   = pc_i + disp_ext;
   assign seq_pc    = pc_i + PC_W'(1);
   assign next_pc_o = taken_i ? jump_pc : seq_pc;
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
   import brcond_pkg::*;
#(
   parameter int unsigned PC_W   = 16,
   parameter int unsigned DISP_W = 8,
   parameter int unsigned MASK_W = FLG_COUNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              fam_i,
   input  logic [MASK_W-1:0] mask_i,
   input  logic              flag_sign_i,
   input  logic              flag_carry_i,
   input  logic              flag_zero_i,
   input  logic              flag_ovf_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic              taken_o,
   output logic [PC_W-1:0]   next_pc_o,
   output logic              done_o
);
   if (MASK_W != FLG_COUNT) begin : g_bad_mask
      $error("MASK_W must equal the flag count");
   end

   logic [MASK_W-1:0] flags;
   logic              taken_d;
   logic [PC_W-1:0]   next_pc_d;

   always_comb begin
      flags            = '0;
      flags[FLG_SIGN]  = flag_sign_i;
      flags[FLG_CARRY] = flag_carry_i;
      flags[FLG_ZERO]  = flag_zero_i;
      flags[FLG_OVF]   = flag_ovf_i;
   end

   brcond_eval #(
      .NFLAG     (MASK_W),
      .ANY_FLAGS (FLG_ZERO + 1)
   ) u_eval (
      .fam_i   (fam_i),
      .mask_i  (mask_i),
      .flags_i (flags),
      .taken_o (taken_d)
   );

   brcond_target #(
      .PC_W   (PC_W),
      .DISP_W (DISP_W)
   ) u_target (
      .pc_i      (pc_i),
      .disp_i    (disp_i),
      .taken_i   (taken_d),
      .next_pc_o (next_pc_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_o   <= 1'b0;
         next_pc_o <= '0;
         done_o    <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            taken_o   <= taken_d;
            next_pc_o <= next_pc_d;
         end
      end
   end

   // R2: result pulse follows each start by one cycle
   a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);
   // R10: outputs frozen without a start
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(taken_o) && $stable(next_pc_o)));
   // R5: any-set family with nothing selected never branches
   a_r5_any_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !fam_i && mask_i[2:0] == 3'b000) |=> !taken_o);
   // R7: all-clear family with empty mask always branches
   a_r7_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && fam_i && mask_i == '0) |=> taken_o);
   // R9: fall-through address when not taken
   a_r9_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (taken_o || next_pc_o == PC_W'($past(pc_i) + PC_W'(1))));
   // R3: a selected set flag in the any-set family forces a branch
   a_r3_any_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !fam_i && flag_sign_i && mask_i[0]) |=> taken_o);
endmodule

// File: tb/brcond_unit_tb.sv
`timescale 1ns/1ps
module brcond_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        fam_i = 1'b0;
   logic [3:0]  mask_i = '0;
   logic        flag_sign_i = 1'b0, flag_carry_i = 1'b0, flag_zero_i = 1'b0, flag_ovf_i = 1'b0;
   logic [15:0] pc_i = '0;
   logic [7:0]  disp_i = '0;
   logic        taken_o;
   logic [15:0] next_pc_o;
   logic        done_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   brcond_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fam_i(fam_i), .mask_i(mask_i),
      .flag_sign_i(flag_sign_i), .flag_carry_i(flag_carry_i),
      .flag_zero_i(flag_zero_i), .flag_ovf_i(flag_ovf_i),
      .pc_i(pc_i), .disp_i(disp_i),
      .taken_o(taken_o), .next_pc_o(next_pc_o), .done_o(done_o)
   );

   // entry: fam | mask[3:0] | flags {ovf,zero,carry,sign} | pc | disp | expected taken
   localparam int NVEC = 14;
   localparam logic [33:0] VEC [NVEC] = '{
      {1'b0, 4'h1, 4'b0001, 16'h1000, 8'h10, 1'b1},  // R3 sign selected and set
      {1'b0, 4'h2, 4'b0001, 16'h1000, 8'h10, 1'b0},  // R3 carry selected, clear
      {1'b0, 4'h4, 4'b0100, 16'h2000, 8'hF0, 1'b1},  // R3 R8 zero, backward
      {1'b0, 4'h7, 4'b0000, 16'h3000, 8'h05, 1'b0},  // R3 R9 none set
      {1'b0, 4'h8, 4'b1111, 16'h4000, 8'h05, 1'b0},  // R4 R5 only bit 3
      {1'b0, 4'hF, 4'b1000, 16'h4100, 8'h05, 1'b0},  // R4 overflow ignored
      {1'b0, 4'h0, 4'b1111, 16'h4200, 8'h05, 1'b0},  // R5 empty mask
      {1'b1, 4'h0, 4'b1111, 16'hFFF0, 8'h20, 1'b1},  // R7 R8 wrap up
      {1'b1, 4'h8, 4'b1000, 16'h5000, 8'h01, 1'b0},  // R6 overflow set
      {1'b1, 4'h8, 4'b0111, 16'h5000, 8'h01, 1'b1},  // R6 overflow clear
      {1'b1, 4'hF, 4'b0000, 16'h0000, 8'h80, 1'b1},  // R6 R8 wrap down
      {1'b1, 4'h6, 4'b0001, 16'h6000, 8'h7F, 1'b1},  // R6 unselected sign
      {1'b1, 4'h6, 4'b0010, 16'hFFFF, 8'h05, 1'b0},  // R6 R9 wrap to 0
      {1'b0, 4'h3, 4'b0010, 16'h1234, 8'h7F, 1'b1}   // R3 R8 carry
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_pc(input logic [15:0] pc, input logic [7:0] d, input logic tk);
      return tk ? pc + {{8{d[7]}}, d} : pc + 16'd1;
   endfunction

   task automatic drive(input logic f, input logic [3:0] m, input logic [3:0] fl,
                        input logic [15:0] pc, input logic [7:0] d);
      fam_i = f; mask_i = m;
      flag_sign_i = fl[0]; flag_carry_i = fl[1]; flag_zero_i = fl[2]; flag_ovf_i = fl[3];
      pc_i = pc; disp_i = d;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 taken", 32'(taken_o), 0);
      check("R1 next_pc", 32'(next_pc_o), 0);
      check("R1 done", 32'(done_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {15'd0, taken_o, next_pc_o}, 0);
      check("R1 done after release", 32'(done_o), 0);

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][33], VEC[i][32:29], VEC[i][28:25], VEC[i][24:9], VEC[i][8:1]);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check("R2 done pulse", 32'(done_o), 1);
         check("table R3 R4 R5 R6 R7 taken", 32'(taken_o), 32'(VEC[i][0]));
         check("table R8 R9 next_pc", 32'(next_pc_o),
               32'(exp_pc(VEC[i][24:9], VEC[i][8:1], VEC[i][0])));
         @(negedge clk);
         check("R2 done single", 32'(done_o), 0);
      end

      // R10: change inputs with start low; outputs hold previous result
      drive(1'b1, 4'h0, 4'b0000, 16'hABCD, 8'h11);
      @(negedge clk);
      @(negedge clk);
      check("R10 hold taken", 32'(taken_o), 1);
      check("R10 hold next_pc", 32'(next_pc_o), 32'h1234 + 32'h7F);
      check("R10 no done", 32'(done_o), 0);

      // R2 back-to-back starts keep done high
      drive(1'b0, 4'h4, 4'b0000, 16'h0100, 8'h02);
      start_i = 1'b1;
      @(negedge clk);
      check("R2 b2b first done", 32'(done_o), 1);
      check("R9 b2b first pc", 32'(next_pc_o), 32'h0101);
      drive(1'b0, 4'h4, 4'b0100, 16'h0100, 8'hFE);
      @(negedge clk);
      start_i = 1'b0;
      check("R2 b2b second done", 32'(done_o), 1);
      check("R8 b2b second pc", 32'(next_pc_o), 32'h00FE);
      @(negedge clk);
      check("R2 b2b end", 32'(done_o), 0);

      // R7 every flag combination with empty mask in all-clear family
      for (int f = 0; f < 16; f++) begin
         drive(1'b1, 4'h0, 4'(f), 16'h0010, 8'h04);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check("R7 sweep", 32'(taken_o), 1);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule